// File: doc/BRIEF.md
# Fully Associative Write-Through Cache Controller

This controller manages a small fully associative cache placed between a host and a main memory, with 32-bit addresses and 32-bit data. The cache has no index bits. The whole word address is the tag, and every stored tag is compared with it at the same time. A one-hot encoder turns the match vector into the line number that addresses the data array. A cyclic counter picks the line to overwrite when a new word is brought in.

Writes always go through to main memory. A write that misses does not allocate a line. Only read misses fill the cache. The controller keeps the host on hold while an access is in progress, and it talks to main memory through a read strobe, a write strobe and an acknowledge.

The host raises a read or write request for one cycle while the controller is not busy. It then waits for the busy flag to fall. On a read, the returned word is valid on the host data output from that cycle on.

Top module: `fa_wt_cache_ctrl`

## Requirements
- R1: After reset, busy and both memory strobes are low and every cache line is invalid, so the first read of any address fetches from main memory.
- R2: While no request is raised and the controller is idle, it stays idle and issues no main-memory access.
- R3: A read miss performs exactly one main-memory read of the requested address, never raises both strobes at once, and returns the fetched word to the host.
- R4: A read hit performs no main-memory access, returns the word held in the cache, and keeps busy high for exactly 2 cycles.
- R5: A word fetched on a read miss is stored in the cache, so the next read of that address hits.
- R6: A write hit updates the cached word and then performs one main-memory write of the same address and data; a later read of that address hits and returns the new data.
- R7: A write miss performs one main-memory write and allocates no line, so a later read of that address misses.
- R8: Fills go to lines in cyclic order starting at line 0 and wrapping after DEPTH-1, so the earliest-filled line is evicted first, regardless of how often it was read.
- R9: A main-memory strobe, with its address, is held until the acknowledge arrives. With an acknowledge latency of L cycles after the strobe, busy lasts L+3 cycles for a read miss, L+3 cycles for a write hit and L+2 cycles for a write miss.
- R10: A request with read and write both high is treated as a read, and main memory is not written.
- R11: Busy rises in the cycle after a request is accepted, stays high while any memory strobe is active, and falls in the cycle the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read request |
| host_wr | input | 1 | Host write request |
| host_addr | input | 32 | Host word address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read result, valid once busy falls after a read |
| host_wait | output | 1 | Busy: access in progress |
| mem_rd | output | 1 | Main-memory read strobe |
| mem_wr | output | 1 | Main-memory write strobe |
| mem_addr | output | 32 | Main-memory address |
| mem_wdata | output | 32 | Main-memory write data |
| mem_rdata | input | 32 | Main-memory read data |
| mem_ack | input | 1 | Main-memory acknowledge |

## Verification
Read sequences run first cold, then repeated, and then past the cache depth. This separates a fill from a hit and shows which line the counter evicts. A read of a line that was filled early but read often proves that access history is ignored.

Writes are aimed at a cached and an uncached address, each followed by a read. The read's memory traffic and returned value tell the write-through update apart from no-allocate. A request with both read and write high, together with a changed acknowledge latency, exposes request priority and the exact busy window of each path.

// File: rtl/fawt_pkg.sv
package fawt_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_TAGCMP,
        ST_RDDATA,
        ST_MEMRD,
        ST_WRCACHE,
        ST_WRMEM
    } fawt_state_e;
endpackage

// File: rtl/fawt_tag_cam.sv
module fawt_tag_cam #(
    parameter int DEPTH = 4,
    parameter int TAG_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [TAG_W-1:0] srch_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    output logic [DEPTH-1:0] match
);
    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        logic             vld_q, vld_d;
        logic [TAG_W-1:0] tag_q, tag_d;

        always_comb begin
            vld_d = vld_q;
            tag_d = tag_q;
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                vld_d = 1'b1;
                tag_d = wr_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                tag_q <= '0;
            end else begin
                vld_q <= vld_d;
                tag_q <= tag_d;
            end
        end

        assign match[i] = vld_q && (tag_q == srch_tag);
    end
endmodule

// File: rtl/fawt_match_enc.sv
module fawt_match_enc #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [DEPTH-1:0] match,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        hit = |match;
        idx = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/fawt_victim_ctr.sv
module fawt_victim_ctr #(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] ptr_q, ptr_d;

    always_comb begin
        ptr_d = ptr_q;
        if (adv) ptr_d = (ptr_q == IDX_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;
endmodule

// File: rtl/fawt_data_ram.sv
module fawt_data_ram #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/fa_wt_cache_ctrl.sv
module fa_wt_cache_ctrl
    import fawt_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_wait,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    typedef struct packed {
        fawt_state_e       st;
        logic              op_rd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [IDX_W-1:0]  line;
        logic [DATA_W-1:0] rdata;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [DEPTH-1:0]  match;
    logic              hit;
    logic [IDX_W-1:0]  hit_idx;
    logic [IDX_W-1:0]  vic_ptr;
    logic              vic_adv;
    logic              cam_we;
    logic              ram_we;
    logic [DATA_W-1:0] ram_rdata;

    fawt_tag_cam #(.DEPTH(DEPTH), .TAG_W(ADDR_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .srch_tag (ctl_q.addr),
        .wr_en    (cam_we),
        .wr_idx   (ctl_q.line),
        .wr_tag   (ctl_q.addr),
        .match    (match)
    );

    fawt_match_enc #(.DEPTH(DEPTH)) u_enc (
        .match (match),
        .hit   (hit),
        .idx   (hit_idx)
    );

    fawt_victim_ctr #(.DEPTH(DEPTH)) u_vic (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (vic_adv),
        .ptr   (vic_ptr)
    );

    fawt_data_ram #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ctl_q.line),
        .wdata (ctl_q.data),
        .raddr (ctl_q.line),
        .rdata (ram_rdata)
    );

    always_comb begin
        ctl_d   = ctl_q;
        cam_we  = 1'b0;
        ram_we  = 1'b0;
        vic_adv = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (host_rd || host_wr) begin
                    ctl_d.st    = ST_TAGCMP;
                    ctl_d.op_rd = host_rd;
                    ctl_d.addr  = host_addr;
                    ctl_d.data  = host_wdata;
                end
            end
            ST_TAGCMP: begin
                if (ctl_q.op_rd) begin
                    ctl_d.st = hit ? ST_RDDATA : ST_MEMRD;
                end else begin
                    ctl_d.st = hit ? ST_WRCACHE : ST_WRMEM;
                end
                if (hit) ctl_d.line = hit_idx;
            end
            ST_RDDATA: begin
                ctl_d.rdata = ram_rdata;
                ctl_d.st    = ST_IDLE;
            end
            ST_MEMRD: begin
                if (mem_ack) begin
                    ctl_d.data = mem_rdata;
                    ctl_d.line = vic_ptr;
                    ctl_d.st   = ST_WRCACHE;
                end
            end
            ST_WRCACHE: begin
                ram_we = 1'b1;
                if (ctl_q.op_rd) begin
                    cam_we      = 1'b1;
                    vic_adv     = 1'b1;
                    ctl_d.rdata = ctl_q.data;
                    ctl_d.st    = ST_IDLE;
                end else begin
                    ctl_d.st = ST_WRMEM;
                end
            end
            ST_WRMEM: begin
                if (mem_ack) ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign host_wait  = (ctl_q.st != ST_IDLE);
    assign host_rdata = ctl_q.rdata;
    assign mem_rd     = (ctl_q.st == ST_MEMRD);
    assign mem_wr     = (ctl_q.st == ST_WRMEM);
    assign mem_addr   = ctl_q.addr;
    assign mem_wdata  = ctl_q.data;
endmodule

// File: rtl/fawt_ctrl_chk.sv
module fawt_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_rd,
    input logic        host_wr,
    input logic        host_wait,
    input logic        mem_rd,
    input logic        mem_wr,
    input logic        mem_ack,
    input logic [31:0] mem_addr
);
    // R9
    mem_rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_ack) |=> (mem_rd && $stable(mem_addr)));

    // R9
    mem_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_ack) |=> (mem_wr && $stable(mem_addr)));

    // R3
    excl_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr) |-> host_wait);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wait && (host_rd || host_wr)) |=> host_wait);

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_wait && !host_rd && !host_wr) |=> (!host_wait && !mem_rd && !mem_wr));
endmodule

bind fa_wt_cache_ctrl fawt_ctrl_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_wait (host_wait),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .mem_ack   (mem_ack),
    .mem_addr  (mem_addr)
);

// File: tb/fa_wt_cache_ctrl_tb_top.sv
module fa_wt_cache_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_rd = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_wait;
    logic        mem_rd;
    logic        mem_wr;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;

    always #10 clk = ~clk;

    fa_wt_cache_ctrl #(.DEPTH(4)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .host_wait  (host_wait),
        .mem_rd     (mem_rd),
        .mem_wr     (mem_wr),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ack    (mem_ack)
    );

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // main-memory model
    logic [31:0] mem_img [logic [31:0]];
    int lat = 1;
    int cnt = 0;
    int nrd = 0;
    int nwr = 0;

    function automatic logic [31:0] memval(input logic [31:0] a);
        if (mem_img.exists(a)) return mem_img[a];
        return (a ^ 32'h5A5A_0000) + 32'h13;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0;
            cnt = 0;
        end else if ((mem_rd || mem_wr) && !mem_ack) begin
            if (cnt >= lat) begin
                mem_ack = 1'b1;
                cnt = 0;
                if (mem_rd) begin
                    mem_rdata = memval(mem_addr);
                    nrd++;
                end else begin
                    mem_img[mem_addr] = mem_wdata;
                    nwr++;
                end
            end else begin
                cnt++;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    // scoreboard
    typedef struct {
        bit          is_rd;
        logic [31:0] data;
        string       req;
    } sb_t;
    sb_t sbq[$];
    logic prev_wait = 1'b0;

    always @(negedge clk) begin
        if (rst_n && prev_wait && !host_wait) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R11 unexpected completion", 32'd1, 32'd0);
            end else begin
                sb_t it;
                it = sbq.pop_front();
                if (it.is_rd) chk(host_rdata === it.data, it.req, host_rdata, it.data);
            end
        end
        prev_wait = host_wait;
    end

    task automatic access(input bit r, input bit w, input logic [31:0] a, input logic [31:0] d,
                          input int erd, input int ewr, input int ecyc,
                          input logic [31:0] erdata, input string req);
        int rd0;
        int wr0;
        int cyc;
        sb_t it;
        it.is_rd = r;
        it.data  = erdata;
        it.req   = req;
        sbq.push_back(it);
        rd0 = nrd;
        wr0 = nwr;
        host_rd = r;
        host_wr = w;
        host_addr = a;
        host_wdata = d;
        @(negedge clk);
        host_rd = 1'b0;
        host_wr = 1'b0;
        cyc = 0;
        while (host_wait) begin
            cyc++;
            @(negedge clk);
        end
        chk(nrd - rd0 == erd, {req, " mem reads"}, nrd - rd0, erd);
        chk(nwr - wr0 == ewr, {req, " mem writes"}, nwr - wr0, ewr);
        if (ecyc >= 0) chk(cyc == ecyc, {req, " busy cycles"}, cyc, ecyc);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog expired", 32'd0, 32'd1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    localparam logic [31:0] A0 = 32'h0000_1000;
    localparam logic [31:0] A9 = 32'h0000_2004;
    localparam logic [31:0] A2 = 32'h0000_3008;
    localparam logic [31:0] A3 = 32'h0000_400C;
    localparam logic [31:0] A4 = 32'h0000_5010;
    localparam logic [31:0] D1 = 32'hCAFE_0001;
    localparam logic [31:0] D2 = 32'hBEEF_0002;
    localparam logic [31:0] D3 = 32'hF00D_0003;

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(host_wait == 1'b0, "R1 busy after reset", host_wait, 0);
        chk(mem_rd == 1'b0 && mem_wr == 1'b0, "R1 strobes after reset", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        // R2: idle with no request
        repeat (5) @(negedge clk);
        chk(nrd == 0 && nwr == 0, "R2 idle memory traffic", nrd + nwr, 0);
        chk(host_wait == 1'b0, "R2 idle busy", host_wait, 0);
        lat = 1;
        // R1 R3: cold read misses
        access(1, 0, A0, 0, 1, 0, lat + 3, memval(A0), "R3 R1 cold read miss");
        // R4 R5: repeated read hits
        access(1, 0, A0, 0, 0, 0, 2, memval(A0), "R4 R5 read hit");
        // R6: write hit then read back from cache
        access(0, 1, A0, D1, 0, 1, lat + 3, 0, "R6 write hit");
        chk(memval(A0) == D1, "R6 written through", memval(A0), D1);
        access(1, 0, A0, 0, 0, 0, 2, D1, "R6 read after write hit");
        // R7: write miss no allocate
        access(0, 1, A9, D2, 0, 1, lat + 2, 0, "R7 write miss");
        access(1, 0, A9, 0, 1, 0, lat + 3, D2, "R7 read after write miss");
        // fill remaining lines; R9 with longer latency
        access(1, 0, A2, 0, 1, 0, lat + 3, memval(A2), "R8 fill line 2");
        lat = 4;
        access(1, 0, A3, 0, 1, 0, lat + 3, memval(A3), "R9 read miss latency");
        lat = 1;
        // R8: wrap evicts line 0 (A0, most read)
        access(1, 0, A4, 0, 1, 0, lat + 3, memval(A4), "R8 wrap fill");
        access(1, 0, A9, 0, 0, 0, 2, D2, "R8 line 1 kept");
        access(1, 0, A0, 0, 1, 0, lat + 3, D1, "R8 oldest evicted");
        access(1, 0, A9, 0, 1, 0, lat + 3, D2, "R8 next victim evicted");
        // R10: both high treated as read
        access(1, 1, A3, D3, 0, 0, 2, memval(A3), "R10 both requests");
        chk(memval(A3) != D3, "R10 memory untouched", memval(A3), 0);
        // R9 R6: write hit with long latency
        lat = 4;
        access(0, 1, A4, D3, 0, 1, lat + 3, 0, "R9 R6 write hit latency");
        access(1, 0, A4, 0, 0, 0, 2, D3, "R6 cache updated");
        chk(sbq.size() == 0, "R11 scoreboard drained", sbq.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule